// File: doc/BRIEF.md
# Fault Response Matrix Unit

This block takes four fault lines and decides, cycle by cycle, which corrective actions the system should take. Each fault can be ignored through a mask bit. If it is not ignored, a per-fault row of a programmable matrix selects any mix of five actions. The actions are: clamping the parallel outputs (active low), raising a fault interrupt, halting, and starting one or both of two programmable reset pulses. The actions requested by all unmasked active faults are OR-ed together.

Alongside the routing, the block keeps recovery data that software reads once the fault has gone. It runs an off-line timer that counts 1 MHz ticks for as long as any unmasked fault is present. It keeps a saturating event counter of fault onsets, and it records which faults took part in the most recent outage. The two reset outputs fire after a mapped fault clears, not while it is present. Each stays high for a programmed number of 100 kHz ticks, so the system leaves its safe state with a clean reset. Both tick rates arrive as single-cycle strobe inputs.

Top module: `fault_resp_unit`

## Requirements
- R1: After a cycle with `rst_i` high, `clamp_n_o` is 1 and `irq_o`, `halt_o`, `sys_rst_o`, `offline_time_o`, `event_cnt_o` and `last_faults_o` are all zero.
- R2: A fault whose `mask_i` bit is 1 has no effect: it drives no action, does not advance the event counter, and does not start or extend the off-line timer.
- R3: The action vector is the OR of the `map_i` rows (row f is bits [5f+4:5f]) of all unmasked active faults. Bit 0 is clamp, bit 1 is interrupt, bit 2 is halt, bit 3 is reset pulse 0 and bit 4 is reset pulse 1. `irq_o` and `halt_o` show bits 1 and 2 one clock after the inputs are sampled.
- R4: `clamp_n_o` is the inverse of action bit 0, so it is driven low one clock after a fault mapped to clamp is sampled.
- R5: `event_cnt_o` rises by the number of unmasked faults that became active in a cycle (active now, inactive in the previous cycle), visible one clock later, and saturates at its all-ones value.
- R6: In the first cycle of an outage (some unmasked fault active after none), `offline_time_o` is cleared to zero. In each later cycle of that outage with `tick_us_i` high, it rises by one and saturates. It holds its value while no unmasked fault is active.
- R7: `last_faults_o` is loaded with the unmasked active faults when an outage starts, gathers every further unmasked active fault during it, and holds after it ends.
- R8: When action bit 3+k goes from 1 to 0, `sys_rst_o[k]` goes high on the next clock and stays high for exactly `rst_len0_i` (k=0) or `rst_len1_i` (k=1) `tick_slow_i` strobes. A length of zero gives no pulse. The pulse is cut short while action bit 3+k is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fault_i | input | 4 | Fault lines, active high |
| mask_i | input | 4 | 1 ignores the matching fault |
| map_i | input | 20 | Action matrix, 5 bits per fault |
| tick_us_i | input | 1 | 1 MHz strobe for the off-line timer |
| tick_slow_i | input | 1 | 100 kHz strobe for the reset pulses |
| rst_len0_i | input | 8 | Length of reset pulse 0 in slow ticks |
| rst_len1_i | input | 8 | Length of reset pulse 1 in slow ticks |
| clamp_n_o | output | 1 | Output clamp, active low |
| irq_o | output | 1 | Fault interrupt |
| halt_o | output | 1 | Halt request |
| sys_rst_o | output | 2 | Programmed reset pulses |
| offline_time_o | output | 24 | Outage length in 1 MHz ticks |
| event_cnt_o | output | 32 | Saturating count of fault onsets |
| last_faults_o | output | 4 | Faults seen in the latest outage |

## Verification
A corrupted previous-cycle fault register would show at once as an extra or missing count on `event_cnt_o`. It would also cause an early timer clear or a wrong `last_faults_o` one clock after the next fault edge. A wrong stored action vector shows up as a reset pulse that is missing, early or of the wrong length on `sys_rst_o`, one clock after the mapped fault clears. The pulse length is then off by whole slow-tick periods. The bench compares every output against a cycle model in every cycle, so a slip of one clock in any of these paths is caught on the cycle it happens.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int NUM_FLT = 4;
    localparam int NUM_ACT = 5;
    localparam int NUM_RST = 2;

    typedef enum int {
        ACT_CLAMP = 0,
        ACT_IRQ   = 1,
        ACT_HALT  = 2,
        ACT_RST0  = 3
    } act_idx_e;

    typedef logic [NUM_FLT-1:0]         flt_vec_t;
    typedef logic [NUM_ACT-1:0]         act_vec_t;
    typedef logic [NUM_FLT*NUM_ACT-1:0] matrix_t;

    typedef struct packed {
        flt_vec_t live;
        flt_vec_t onset;
        logic     outage_start;
        logic     outage_on;
    } flt_state_t;

    function automatic act_vec_t route(flt_vec_t live, matrix_t mtx);
        act_vec_t acc = '0;
        for (int f = 0; f < NUM_FLT; f++) begin
            if (live[f]) acc = acc | mtx[f*NUM_ACT +: NUM_ACT];
        end
        return acc;
    endfunction

    function automatic int unsigned ones(flt_vec_t v);
        int unsigned n = 0;
        for (int f = 0; f < NUM_FLT; f++) n = n + int'(v[f]);
        return n;
    endfunction
endpackage

// File: rtl/fr_matrix.sv
module fr_matrix
    import fr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  flt_vec_t   fault_i,
    input  flt_vec_t   mask_i,
    input  matrix_t    map_i,
    output flt_state_t st_o,
    output act_vec_t   act_now_o,
    output act_vec_t   act_q_o
);
    flt_vec_t live;
    flt_vec_t live_q;
    act_vec_t act_q;

    assign live      = fault_i & ~mask_i;
    assign act_now_o = route(live, map_i);
    assign act_q_o   = act_q;

    always_comb begin
        st_o.live         = live;
        st_o.onset        = live & ~live_q;
        st_o.outage_on    = |live;
        st_o.outage_start = (|live) && !(|live_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            live_q <= '0;
            act_q  <= '0;
        end else begin
            live_q <= live;
            act_q  <= act_now_o;
        end
    end
endmodule

// File: rtl/fr_event_log.sv
module fr_event_log
    import fr_pkg::*;
#(
    parameter int TIM_W = 24,
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  flt_state_t       st_i,
    input  logic             tick_us_i,
    output logic [TIM_W-1:0] timer_o,
    output logic [CNT_W-1:0] count_o,
    output flt_vec_t         last_o
);
    localparam logic [TIM_W-1:0] TIM_MAX = '1;

    logic [CNT_W:0] cnt_sum;

    assign cnt_sum = {1'b0, count_o} + (CNT_W+1)'(ones(st_i.onset));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            timer_o <= '0;
            count_o <= '0;
            last_o  <= '0;
        end else begin
            count_o <= cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
            if (st_i.outage_start) begin
                timer_o <= '0;
                last_o  <= st_i.live;
            end else if (st_i.outage_on) begin
                last_o <= last_o | st_i.live;
                if (tick_us_i && timer_o != TIM_MAX) timer_o <= timer_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fr_reset_pulse.sv
module fr_reset_pulse #(
    parameter int LEN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_now_i,
    input  logic             req_q_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic             pulse_o
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk_i) begin
        if (rst_i)                            remain <= '0;
        else if (req_q_i && !req_now_i)       remain <= len_i;
        else if (req_now_i)                   remain <= '0;
        else if (tick_i && remain != '0)      remain <= remain - 1'b1;
    end

    assign pulse_o = (remain != '0);
endmodule

// File: rtl/fault_resp_unit.sv
module fault_resp_unit
    import fr_pkg::*;
#(
    parameter int TIM_W = 24,
    parameter int CNT_W = 32,
    parameter int LEN_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [NUM_FLT-1:0]         fault_i,
    input  logic [NUM_FLT-1:0]         mask_i,
    input  logic [NUM_FLT*NUM_ACT-1:0] map_i,
    input  logic                       tick_us_i,
    input  logic                       tick_slow_i,
    input  logic [LEN_W-1:0]           rst_len0_i,
    input  logic [LEN_W-1:0]           rst_len1_i,
    output logic                       clamp_n_o,
    output logic                       irq_o,
    output logic                       halt_o,
    output logic [NUM_RST-1:0]         sys_rst_o,
    output logic [TIM_W-1:0]           offline_time_o,
    output logic [CNT_W-1:0]           event_cnt_o,
    output logic [NUM_FLT-1:0]         last_faults_o
);
    flt_state_t       st;
    act_vec_t         act_now;
    act_vec_t         act_q;
    logic [LEN_W-1:0] lens [NUM_RST];

    assign lens[0] = rst_len0_i;
    assign lens[1] = rst_len1_i;

    fr_matrix u_matrix (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .fault_i   (fault_i),
        .mask_i    (mask_i),
        .map_i     (map_i),
        .st_o      (st),
        .act_now_o (act_now),
        .act_q_o   (act_q)
    );

    fr_event_log #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_log (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .st_i      (st),
        .tick_us_i (tick_us_i),
        .timer_o   (offline_time_o),
        .count_o   (event_cnt_o),
        .last_o    (last_faults_o)
    );

    for (genvar k = 0; k < NUM_RST; k++) begin : g_rst
        fr_reset_pulse #(.LEN_W(LEN_W)) u_pulse (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .req_now_i (act_now[int'(ACT_RST0) + k]),
            .req_q_i   (act_q[int'(ACT_RST0) + k]),
            .len_i     (lens[k]),
            .tick_i    (tick_slow_i),
            .pulse_o   (sys_rst_o[k])
        );
    end

    assign clamp_n_o = ~act_q[ACT_CLAMP];
    assign irq_o     = act_q[ACT_IRQ];
    assign halt_o    = act_q[ACT_HALT];
endmodule

// File: rtl/fr_chk.sv
module fr_chk
    import fr_pkg::*;
#(
    parameter int TIM_W = 24,
    parameter int CNT_W = 32,
    parameter int LEN_W = 8
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic [NUM_FLT-1:0]         fault_i,
    input logic [NUM_FLT-1:0]         mask_i,
    input logic [NUM_FLT*NUM_ACT-1:0] map_i,
    input logic                       tick_us_i,
    input logic                       tick_slow_i,
    input logic [LEN_W-1:0]           rst_len0_i,
    input logic [LEN_W-1:0]           rst_len1_i,
    input logic                       clamp_n_o,
    input logic                       irq_o,
    input logic                       halt_o,
    input logic [NUM_RST-1:0]         sys_rst_o,
    input logic [TIM_W-1:0]           offline_time_o,
    input logic [CNT_W-1:0]           event_cnt_o,
    input logic [NUM_FLT-1:0]         last_faults_o
);
    logic       primed;
    logic [3:0] live;

    assign live = fault_i & ~mask_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) primed <= 1'b0;
        else       primed <= 1'b1;
    end

    // R5
    cnt_no_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        primed |-> event_cnt_o >= $past(event_cnt_o));

    // R5
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        primed |-> (event_cnt_o - $past(event_cnt_o)) <= CNT_W'(NUM_FLT));

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (primed && $past(live) == '0) |-> (clamp_n_o && !irq_o && !halt_o));

    // R6
    timer_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (primed && $past(live) == '0) |-> $stable(offline_time_o));
endmodule

bind fault_resp_unit fr_chk #(.TIM_W(TIM_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/fault_resp_unit_tb.sv
module fault_resp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  fault, mask;
    logic [19:0] map;
    logic        tus, tslow;
    logic [7:0]  len0, len1;
    logic        clamp_n, irq, halt;
    logic [1:0]  srst;
    logic [23:0] otime;
    logic [31:0] ecnt;
    logic [3:0]  lastf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fault_resp_unit dut_i (
        .clk_i(clk), .rst_i(rst), .fault_i(fault), .mask_i(mask), .map_i(map),
        .tick_us_i(tus), .tick_slow_i(tslow), .rst_len0_i(len0), .rst_len1_i(len1),
        .clamp_n_o(clamp_n), .irq_o(irq), .halt_o(halt), .sys_rst_o(srst),
        .offline_time_o(otime), .event_cnt_o(ecnt), .last_faults_o(lastf)
    );

    // bench model state
    logic [3:0]  m_live_q;
    logic [4:0]  m_act_q;
    logic [23:0] m_time;
    logic [31:0] m_cnt;
    logic [3:0]  m_last;
    logic [7:0]  m_rem [2];

    function automatic logic [4:0] actions(logic [3:0] live, logic [19:0] mtx);
        logic [4:0] a = '0;
        for (int f = 0; f < 4; f++) if (live[f]) a |= mtx[f*5 +: 5];
        return a;
    endfunction

    function automatic int onsets(logic [3:0] v);
        int n = 0;
        for (int f = 0; f < 4; f++) n += int'(v[f]);
        return n;
    endfunction

    always @(posedge clk) begin
        logic [3:0]  live;
        logic [4:0]  a;
        logic [32:0] s;
        live = fault & ~mask;
        a    = actions(live, map);
        if (rst) begin
            m_live_q = '0; m_act_q = '0; m_time = '0; m_cnt = '0; m_last = '0;
            m_rem[0] = '0; m_rem[1] = '0;
        end else begin
            s = {1'b0, m_cnt} + 33'(onsets(live & ~m_live_q));
            m_cnt = s[32] ? 32'hFFFF_FFFF : s[31:0];
            if (|live && !(|m_live_q)) begin
                m_time = '0; m_last = live;
            end else if (|live) begin
                m_last |= live;
                if (tus && m_time != 24'hFF_FFFF) m_time = m_time + 1;
            end
            for (int k = 0; k < 2; k++) begin
                if (m_act_q[3+k] && !a[3+k]) m_rem[k] = (k == 0) ? len0 : len1;
                else if (a[3+k])             m_rem[k] = '0;
                else if (tslow && m_rem[k] != 0) m_rem[k] = m_rem[k] - 1;
            end
            m_live_q = live;
            m_act_q  = a;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && cycles > 2) begin
            check({clamp_n, irq, halt} == {~m_act_q[0], m_act_q[1], m_act_q[2]},
                  "R3 actions", {clamp_n, irq, halt}, {~m_act_q[0], m_act_q[1], m_act_q[2]});
            check(ecnt == m_cnt, "R5 event count", ecnt, m_cnt);
            check(otime == m_time, "R6 offline timer", otime, m_time);
            check(lastf == m_last, "R7 last faults", lastf, m_last);
            check(srst == {m_rem[1] != 0, m_rem[0] != 0}, "R8 reset pulses",
                  srst, {m_rem[1] != 0, m_rem[0] != 0});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int hi;
        logic [31:0] c0;
        void'($urandom(32'd4242));
        rst = 1'b1; fault = '0; mask = '0; map = '0; tus = 0; tslow = 0; len0 = 0; len1 = 0;
        step(4);
        // R1 reset state
        check(clamp_n == 1'b1 && irq == 0 && halt == 0 && srst == 0,
              "R1 reset outputs", {clamp_n, irq, halt, srst}, 5'b10000);
        check(otime == 0 && ecnt == 0 && lastf == 0, "R1 reset recovery data",
              {otime, ecnt, lastf}, 0);
        rst = 1'b0;

        // R4 clamp active low
        map = 20'h00001; fault = 4'b0001;
        step(1);
        check(clamp_n == 1'b0 && irq == 1'b0, "R4 clamp low", {clamp_n, irq}, 2'b00);
        fault = '0;
        step(1);
        check(clamp_n == 1'b1, "R4 clamp released", clamp_n, 1);

        // random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 250 == 0) begin
                mask = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
                map  = 20'($urandom);
                len0 = 8'($urandom_range(0, 7));
                len1 = 8'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 5) == 0) fault = 4'($urandom);
            tus   = ($urandom_range(0, 3) == 0);
            tslow = ($urandom_range(0, 7) == 0);
            step(1);
        end

        // drain
        fault = '0; mask = '0; map = '0; tslow = 1; tus = 0;
        step(20);

        // R8 pulse length, directed
        len0 = 8'd3; map = 20'h1 << (1*5 + 3); fault = 4'b0010;
        step(3);
        check(srst[0] == 1'b0, "R8 no pulse while fault present", srst[0], 0);
        fault = '0;
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            hi += int'(srst[0]);
        end
        check(hi == 3, "R8 pulse width", hi, 3);
        len0 = 8'd0; fault = 4'b0010; step(2); fault = '0;
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            hi += int'(srst[0]);
        end
        check(hi == 0, "R8 zero length", hi, 0);

        // R2 masked faults have no effect
        mask = 4'hF; map = '1; c0 = ecnt;
        for (int i = 0; i < 20; i++) begin
            fault = 4'($urandom);
            tus = 1;
            step(1);
            check(clamp_n && !irq && !halt && srst == 0, "R2 masked outputs",
                  {clamp_n, irq, halt, srst}, 5'b10000);
        end
        check(ecnt == c0, "R2 masked count", ecnt, c0);

        // R5 two simultaneous onsets
        fault = '0; mask = '0; step(2);
        c0 = ecnt; fault = 4'b1010; step(1);
        check(ecnt == c0 + 2, "R5 double onset", ecnt, c0 + 2);
        fault = '0; step(12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule